// File: doc/BRIEF.md
# Sequential Shift-Add Unsigned Multiplier

This block multiplies two unsigned 32-bit integers and returns the full 64-bit product. It does one step of the binary long-multiplication method in each clock cycle. The multiplicand is held fixed in its own register. A single 64-bit accumulator starts with the multiplier in its low half and zero in its high half. In each step, the low bit of the accumulator decides whether the multiplicand is added to the high half, using one 32-bit adder. The whole accumulator, with the adder's carry at its top, then moves right by one place. After 32 steps, the accumulator holds the product.

A client raises `start` for one cycle with both operands present. It then waits for `done`, which is high for exactly one cycle, and reads `product_o`. The controller has three states. `ST_IDLE` moves to `ST_RUN` when start is accepted (`T_LAUNCH`). `ST_RUN` stays in itself for each of the first 31 steps (`T_STEP`) and moves to `ST_DONE` on the 32nd step (`T_FINISH`). `ST_DONE` moves back to `ST_RUN` if start arrives in that cycle (`T_RELAUNCH`); otherwise it moves to `ST_IDLE` (`T_REST`). A synchronous reset takes any state to `ST_IDLE` (`T_RESET`).

Top module: `seqmul_top`

## Requirements
- R1: A synchronous active-high reset clears the accumulator and the step counter and returns the controller to idle. In the cycle after reset, busy_o = 0, done_o = 0 and product_o = 0.
- R2: When start is high at a rising edge and busy_o is low, the block latches the multiplicand and multiplier. From the next cycle, busy_o is high and product_o equals the multiplier zero-extended to 64 bits.
- R3: After an accepted start, busy_o stays high for exactly 32 cycles. done_o is high for exactly the one cycle that follows them, and busy_o and done_o are never high together.
- R4: In the cycle where done_o is high, product_o equals the exact 64-bit unsigned product of the latched operands.
- R5: After done_o, product_o keeps the product and done_o stays low until the next accepted start.
- R6: start is ignored while busy_o is high. The operands are not re-latched, and neither the 32-cycle timing nor the result changes.
- R7: A zero operand gives a zero product. 0xFFFFFFFF × 0xFFFFFFFF gives 0xFFFFFFFE00000001, which needs the adder carry to reach bit 63.
- R8: While busy, after i completed steps product_o equals (mcand × (mplier mod 2^i)) shifted left by 32−i, OR-ed with (mplier >> i).
- R9: A start in the cycle where done_o is high is accepted, so a new operation can follow with no idle cycle between the two.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start request, sampled when not busy |
| mcand_i | input | 32 | Multiplicand operand |
| mplier_i | input | 32 | Multiplier operand |
| busy_o | output | 1 | High while the 32 steps run |
| done_o | output | 1 | One-cycle completion pulse |
| product_o | output | 64 | Accumulator contents; the product when done_o is high |

## Verification
Because product_o exposes the accumulator on every cycle, a bad add decision, a wrong shift or a lost carry shows up in the very cycle after the faulty step. It is caught by comparing the port against the partial-product formula of R8. A counter that is off by one shifts the done_o pulse by a cycle and leaves the product scaled by two, and both are visible at the end of the run. Re-latching the operands during a run shows up within one cycle as a divergence from the expected partial product.

// File: rtl/seqmul_pkg.sv
package seqmul_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } seqmul_state_e;

endpackage

// File: rtl/seqmul_adder.sv
// Ripple-carry adder of two W-bit words with the carry kept as bit W.
module seqmul_adder #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W:0]   sum
);

    logic [W:0] carry;

    assign carry[0] = 1'b0;

    for (genvar k = 0; k < W; k++) begin : g_bit
        assign sum[k]     = a[k] ^ b[k] ^ carry[k];
        assign carry[k+1] = (a[k] & b[k]) | (carry[k] & (a[k] ^ b[k]));
    end

    assign sum[W] = carry[W];

endmodule

// File: rtl/seqmul_ctrl.sv
// Controller: state register, step counter, and decoded outputs.
module seqmul_ctrl
    import seqmul_pkg::*;
#(
    parameter int W = 32
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic load,
    output logic step,
    output logic busy,
    output logic done
);

    localparam int CW = (W > 1) ? $clog2(W) : 1;
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    seqmul_state_e state_q, state_d;
    logic [CW-1:0] cnt_q;
    logic          last_step;

    assign last_step = (cnt_q == LAST);

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start) state_d = ST_RUN;                 // T_LAUNCH
            ST_RUN:  if (last_step) state_d = ST_DONE;            // T_FINISH / T_STEP
            ST_DONE: state_d = start ? ST_RUN : ST_IDLE;          // T_RELAUNCH / T_REST
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;                                   // T_RESET
        end else begin
            state_q <= state_d;
        end
    end

    // Step counter
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= '0;
        end else if (step) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Outputs decoded from the state
    always_comb begin
        load = 1'b0;
        step = 1'b0;
        busy = 1'b0;
        done = 1'b0;
        unique case (state_q)
            ST_IDLE: load = start;
            ST_RUN: begin
                step = 1'b1;
                busy = 1'b1;
            end
            ST_DONE: begin
                done = 1'b1;
                load = start;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/seqmul_datapath.sv
// Fixed multiplicand register plus a combined multiplier/product accumulator.
module seqmul_datapath #(
    parameter int W = 32
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           load,
    input  logic           step,
    input  logic [W-1:0]   mcand,
    input  logic [W-1:0]   mplier,
    output logic [2*W-1:0] acc
);

    localparam int PW = 2 * W;

    logic [W-1:0]  mcand_q;
    logic [PW-1:0] acc_q;
    logic [W-1:0]  addend;
    logic [W:0]    upper_sum;

    // Add the multiplicand only when the current low bit is set.
    assign addend = acc_q[0] ? mcand_q : '0;

    seqmul_adder #(.W(W)) u_add (
        .a   (acc_q[PW-1:W]),
        .b   (addend),
        .sum (upper_sum)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            mcand_q <= '0;
            acc_q   <= '0;
        end else if (load) begin
            mcand_q <= mcand;
            acc_q   <= {{W{1'b0}}, mplier};
        end else if (step) begin
            // Carry lands in the top bit; the low half moves down by one.
            acc_q <= {upper_sum, acc_q[W-1:1]};
        end
    end

    assign acc = acc_q;

endmodule

// File: rtl/seqmul_top.sv
module seqmul_top #(
    parameter int W = 32
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           start,
    input  logic [W-1:0]   mcand_i,
    input  logic [W-1:0]   mplier_i,
    output logic           busy_o,
    output logic           done_o,
    output logic [2*W-1:0] product_o
);

    logic load, step;

    seqmul_ctrl #(.W(W)) u_ctrl (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .load  (load),
        .step  (step),
        .busy  (busy_o),
        .done  (done_o)
    );

    seqmul_datapath #(.W(W)) u_dp (
        .clk    (clk),
        .rst    (rst),
        .load   (load),
        .step   (step),
        .mcand  (mcand_i),
        .mplier (mplier_i),
        .acc    (product_o)
    );

endmodule

// File: rtl/seqmul_chk.sv
module seqmul_chk #(
    parameter int W = 32
) (
    input logic           clk,
    input logic           rst,
    input logic           start,
    input logic [W-1:0]   mcand_i,
    input logic [W-1:0]   mplier_i,
    input logic           busy_o,
    input logic           done_o,
    input logic [2*W-1:0] product_o
);

    localparam int RL = $clog2(W + 1) + 1;

    logic [RL-1:0]  run_len;
    logic [2*W-1:0] op_a, op_b;

    // Counts the busy cycles of the current run.
    always_ff @(posedge clk) begin
        if (rst || !busy_o) run_len <= '0;
        else                run_len <= run_len + 1'b1;
    end

    // Operands captured at the accepted start.
    always_ff @(posedge clk) begin
        if (rst) begin
            op_a <= '0;
            op_b <= '0;
        end else if (start && !busy_o) begin
            op_a <= {{W{1'b0}}, mcand_i};
            op_b <= {{W{1'b0}}, mplier_i};
        end
    end

    // R1
    reset_clears_chk: assert property (@(posedge clk)
        rst |=> (!busy_o && !done_o && product_o == '0));

    // R2
    launch_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (start && !busy_o) |=> (busy_o && product_o == op_b));

    // R3
    busy_done_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(busy_o && done_o));

    // R3
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    // R3
    run_length_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(done_o) |-> (run_len == RL'(W)));

    // R4
    product_exact_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (product_o == op_a * op_b));

    // R5
    product_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && !start) |=> $stable(product_o));

endmodule

bind seqmul_top seqmul_chk #(.W(W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .mcand_i   (mcand_i),
    .mplier_i  (mplier_i),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .product_o (product_o)
);

// File: tb/tb_seqmul_top.sv
`timescale 1ns/1ps
module tb_seqmul_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [31:0] mcand_i = '0;
    logic [31:0] mplier_i = '0;
    logic        busy_o, done_o;
    logic [63:0] product_o;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #4 clk = ~clk;   // 125 MHz

    seqmul_top dut (
        .clk(clk), .rst(rst), .start(start),
        .mcand_i(mcand_i), .mplier_i(mplier_i),
        .busy_o(busy_o), .done_o(done_o), .product_o(product_o)
    );

    // Behavioural reference model: 0 idle, 1 running, 2 done
    int          m_state = 0;
    int          m_it = 0;
    logic [63:0] m_a = '0, m_b = '0, m_prod = '0;
    bit          m_live = 0;

    always @(posedge clk) begin
        m_live = 1;
        if (rst) begin
            m_state = 0; m_prod = '0; m_it = 0;
        end else if (m_state == 1) begin
            m_it = m_it + 1;
            m_prod = ((m_a * (m_b & ((64'd1 << m_it) - 64'd1))) << (32 - m_it)) | (m_b >> m_it);
            if (m_it == 32) m_state = 2;
        end else if (start) begin
            m_a = {32'd0, mcand_i}; m_b = {32'd0, mplier_i};
            m_prod = m_b; m_it = 0; m_state = 1;
        end else begin
            m_state = 0;
        end
    end

    // Every-cycle comparison against the model (R8 partial products, R3 flags)
    always @(negedge clk) begin
        if (m_live && !finished) begin
            checks++;
            if (busy_o !== (m_state == 1) || done_o !== (m_state == 2)) begin
                errors++;
                $display("FAIL R3 flags busy=%0b done=%0b expected busy=%0b done=%0b",
                         busy_o, done_o, m_state == 1, m_state == 2);
            end
            checks++;
            if (product_o !== m_prod) begin
                errors++;
                $display("FAIL R8 product_o=%h expected %h (step %0d)", product_o, m_prod, m_it);
            end
        end
    end

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Starts at a negedge, returns at the negedge where done_o is high.
    task automatic do_mul(input logic [31:0] a, input logic [31:0] b,
                          input string req, input bit poke);
        int bcnt = 0;
        int guard = 0;
        start = 1'b1; mcand_i = a; mplier_i = b;
        @(negedge clk);
        start = 1'b0;
        check("R2 busy after start", {63'd0, busy_o}, 64'd1);
        check("R2 product_o loaded with multiplier", product_o, {32'd0, b});
        while (!done_o && guard < 100) begin
            if (busy_o) bcnt++;
            guard++;
            if (poke && bcnt == 10) begin
                start = 1'b1; mcand_i = ~a; mplier_i = ~b;   // R6 ignored
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
        end
        start = 1'b0;
        check("R3 busy cycle count", 64'(bcnt), 64'd32);
        check({req, " product"}, product_o, {32'd0, a} * {32'd0, b});
    endtask

    task automatic hold_check(input logic [63:0] exp);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check("R5 product held", product_o, exp);
            check("R5 done low, idle", {62'd0, done_o, busy_o}, 64'd0);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset state", {busy_o, done_o, product_o[61:0]}, 64'd0);
        check("R1 reset product", product_o, 64'd0);
        rst = 1'b0;
        @(negedge clk);

        do_mul(32'd11, 32'd13, "R4", 0);
        check("R4 11*13", product_o, 64'd143);
        hold_check(64'd143);

        do_mul(32'd2, 32'd3, "R4", 0);
        hold_check(64'd6);

        do_mul(32'd156, 32'd99, "R4", 0);
        check("R4 156*99", product_o, 64'd15444);
        @(negedge clk);

        do_mul(32'hFFFF_FFFF, 32'hFFFF_FFFF, "R7", 0);
        check("R7 all-ones squared", product_o, 64'hFFFF_FFFE_0000_0001);
        @(negedge clk);

        do_mul(32'd0, 32'hDEAD_BEEF, "R7", 0);
        check("R7 zero multiplicand", product_o, 64'd0);
        @(negedge clk);

        do_mul(32'h1234_5678, 32'd0, "R7", 0);
        check("R7 zero multiplier", product_o, 64'd0);
        @(negedge clk);

        do_mul(32'hA5A5_0F0F, 32'h8000_0003, "R6", 1);
        hold_check({32'd0, 32'hA5A5_0F0F} * {32'd0, 32'h8000_0003});

        // R9: back-to-back, new start in the done cycle
        do_mul(32'h8000_0000, 32'd2, "R9 first", 0);
        do_mul(32'hFFFF_FFFF, 32'd7, "R9 second", 0);
        check("R9 back-to-back result", product_o, 64'h6_FFFF_FFF9);
        hold_check(64'h6_FFFF_FFF9);

        // R1 reset mid-run
        start = 1'b1; mcand_i = 32'd5; mplier_i = 32'd9;
        @(negedge clk);
        start = 1'b0;
        repeat (5) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check("R1 reset mid-run", {busy_o, done_o, product_o[61:0]}, 64'd0);
        rst = 1'b0;
        @(negedge clk);

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule